// File: doc/BRIEF.md
# Multi-Route I/Q Signal Adder

This block sits directly in front of one output channel's DAC. It passes that channel's own I/Q sample stream through. When its router is enabled, it adds up to three extra I/Q streams to that stream. Each extra stream is drawn from a bank of source channels. The bank streams arrive already scaled and phase-rotated, so the block only selects, sums and limits them. I and Q are handled independently.

Each of the three routes has an enable bit and a source index. One master enable switches the whole block between two paths:
- Bypass path: one register stage.
- Summing path: adds a further `EXTRA_LAT` (default 52) sample periods. This lets channels that share signals keep matching timing.

Routes with illegal sources are dropped, and a sticky error flag records the illegal configuration. Sums that leave the 16-bit range are clamped, and each clipped sample is counted. Marker bits travel only with the channel's own data.

Samples are 16-bit two's complement, with full scale corresponding to ±1.

Top module: `iqsum_router`

## Requirements
- R1: With `rtr_en_i` low, `out_i_o`/`out_q_o` equal `own_i_i`/`own_q_i` from one cycle earlier. The bank inputs and route settings have no effect on the output.
- R2: With `rtr_en_i` high, a sample presented at the inputs appears at the outputs 1+`EXTRA_LAT` cycles later (53 by default), which is `EXTRA_LAT` cycles later than in bypass.
- R3: With `rtr_en_i` high, each output component is the own component plus the bank component of every accepted route. Route r's source index is `route_src_i[r*SRC_W +: SRC_W]`, and source s occupies `bank_*_i[s*16 +: 16]`.
- R4: A route whose bit in `route_en_i` is 0 contributes nothing, and its source index is never judged.
- R5: An enabled route is dropped if its source equals `CH_IDX` or is not below `NUM_SRC`. The same applies when the source duplicates an accepted lower-numbered route (R6). A dropped route sets `cfg_err_o` at the next edge, but only while `rtr_en_i` is high. The flag then stays set until `clr_i`.
- R6: When two enabled routes name the same legal source, the lower-numbered route is kept, the higher one is dropped, and `cfg_err_o` is set.
- R7: A sum above 32767 is output as 32767, and a sum below -32768 is output as -32768.
- R8: `ovf_cnt_o` rises by one per input sample for which I, Q or both clip while `rtr_en_i` is high. It is held while `rtr_en_i` is low.
- R9: `ovf_cnt_o` (`CNT_W` bits) stops at its all-ones value instead of wrapping. `clr_i` zeroes both `ovf_cnt_o` and `cfg_err_o` at the next edge. Reset zeroes both, as well as the data outputs.
- R10: `mark_o` carries `mark_i` with the same latency as the data on both paths. Nothing from other channels ever reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rtr_en_i | input | 1 | Master enable: summing path when high, bypass when low |
| route_en_i | input | NUM_ROUTES | Per-route enable |
| route_src_i | input | NUM_ROUTES*SRC_W | Per-route source channel index |
| clr_i | input | 1 | Clears overflow counter and config error flag |
| own_i_i | input | 16 | Own channel I sample |
| own_q_i | input | 16 | Own channel Q sample |
| mark_i | input | MARK_W | Own channel marker bits |
| bank_i_i | input | NUM_SRC*16 | Pre-transformed I samples of all source channels |
| bank_q_i | input | NUM_SRC*16 | Pre-transformed Q samples of all source channels |
| out_i_o | output | 16 | I sample toward the DAC |
| out_q_o | output | 16 | Q sample toward the DAC |
| mark_o | output | MARK_W | Delayed marker bits |
| ovf_cnt_o | output | CNT_W | Saturating overflow event count |
| cfg_err_o | output | 1 | Sticky illegal-source flag |

## Verification
The bench targets the following corner cases:
- **Source rules.** It covers a route naming its own channel, an out-of-range index, and two routes sharing a source. A design that dropped the wrong route of a duplicate pair would give a visibly different sum. So would one that let a self-route through.
- **Disabled routes.** A disabled route carries a forbidden or duplicated index. A design that judged disabled routes would raise the error flag or lose a valid route.
- **Clipping.** Clips are driven at both rails, including one sample that clips in I and Q together. A counter that counted per axis would read two instead of one.
- **Counter saturation.** The counter is held at its limit to expose wrapping.
- **Latency.** A single-sample pulse is checked one cycle before and at its due cycle, which exposes an off-by-one in the 52-stage alignment.

// File: rtl/iqsum_pkg.sv
package iqsum_pkg;
  localparam int unsigned SAMPLE_W = 16;
  typedef logic signed [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/iqsum_route_chk.sv
module iqsum_route_chk #(
  parameter int unsigned NUM_ROUTES = 3,
  parameter int unsigned NUM_SRC    = 6,
  parameter int unsigned CH_IDX     = 0,
  parameter int unsigned SRC_W      = 3
) (
  input  logic [NUM_ROUTES-1:0]       route_en_i,
  input  logic [NUM_ROUTES*SRC_W-1:0] route_src_i,
  output logic [NUM_ROUTES-1:0]       route_ok_o,
  output logic [NUM_ROUTES-1:0]       route_bad_o
);
  logic [NUM_ROUTES-1:0] legal;

  for (genvar r = 0; r < NUM_ROUTES; r++) begin : g_legal
    logic [SRC_W-1:0] src;
    assign src      = route_src_i[r*SRC_W +: SRC_W];
    assign legal[r] = (int'(src) < int'(NUM_SRC)) && (int'(src) != int'(CH_IDX));
  end

  // lower route wins on a shared source
  always_comb begin : p_accept
    logic [NUM_ROUTES-1:0] acc;
    acc = '0;
    for (int r = 0; r < NUM_ROUTES; r++) begin
      acc[r] = route_en_i[r] && legal[r];
      for (int p = 0; p < NUM_ROUTES; p++) begin
        if (p < r && acc[p] &&
            route_src_i[p*SRC_W +: SRC_W] == route_src_i[r*SRC_W +: SRC_W])
          acc[r] = 1'b0;
      end
    end
    route_ok_o = acc;
  end

  assign route_bad_o = route_en_i & ~route_ok_o;
endmodule

// File: rtl/iqsum_adder.sv
module iqsum_adder
  import iqsum_pkg::*;
#(
  parameter int unsigned NUM_ROUTES = 3,
  parameter int unsigned NUM_SRC    = 6,
  parameter int unsigned SRC_W      = 3
) (
  input  sample_t                     own_i_i,
  input  sample_t                     own_q_i,
  input  logic [NUM_SRC*SAMPLE_W-1:0] bank_i_i,
  input  logic [NUM_SRC*SAMPLE_W-1:0] bank_q_i,
  input  logic [NUM_ROUTES-1:0]       route_ok_i,
  input  logic [NUM_ROUTES*SRC_W-1:0] route_src_i,
  output sample_t                     sum_i_o,
  output sample_t                     sum_q_o,
  output logic                        ovf_o
);
  localparam int unsigned GUARD = $clog2(NUM_ROUTES + 1);
  localparam int unsigned ACC_W = SAMPLE_W + GUARD;

  sample_t bi [NUM_SRC];
  sample_t bq [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_unpack
    assign bi[s] = sample_t'(bank_i_i[s*SAMPLE_W +: SAMPLE_W]);
    assign bq[s] = sample_t'(bank_q_i[s*SAMPLE_W +: SAMPLE_W]);
  end

  logic signed [ACC_W-1:0] acc_i, acc_q;

  always_comb begin
    acc_i = ACC_W'(own_i_i);
    acc_q = ACC_W'(own_q_i);
    for (int r = 0; r < NUM_ROUTES; r++) begin
      if (route_ok_i[r]) begin
        acc_i = acc_i + ACC_W'(bi[route_src_i[r*SRC_W +: SRC_W]]);
        acc_q = acc_q + ACC_W'(bq[route_src_i[r*SRC_W +: SRC_W]]);
      end
    end
  end

  // out of range when the guard bits and the sample sign disagree
  logic ov_i, ov_q;
  assign ov_i = !((&acc_i[ACC_W-1:SAMPLE_W-1]) || !(|acc_i[ACC_W-1:SAMPLE_W-1]));
  assign ov_q = !((&acc_q[ACC_W-1:SAMPLE_W-1]) || !(|acc_q[ACC_W-1:SAMPLE_W-1]));

  always_comb begin
    if (ov_i) sum_i_o = acc_i[ACC_W-1] ? {1'b1, {(SAMPLE_W-1){1'b0}}} : {1'b0, {(SAMPLE_W-1){1'b1}}};
    else      sum_i_o = acc_i[SAMPLE_W-1:0];
    if (ov_q) sum_q_o = acc_q[ACC_W-1] ? {1'b1, {(SAMPLE_W-1){1'b0}}} : {1'b0, {(SAMPLE_W-1){1'b1}}};
    else      sum_q_o = acc_q[SAMPLE_W-1:0];
  end

  assign ovf_o = ov_i | ov_q;
endmodule

// File: rtl/iqsum_delay.sv
module iqsum_delay #(
  parameter int unsigned WIDTH = 34,
  parameter int unsigned DEPTH = 52
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);
  if (DEPTH == 0) begin : g_wire
    assign d_o = d_i;
  end else begin : g_pipe
    logic [WIDTH-1:0] pipe [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < DEPTH; k++) pipe[k] <= '0;
      end else begin
        pipe[0] <= d_i;
        for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
      end
    end
    assign d_o = pipe[DEPTH-1];
  end
endmodule

// File: rtl/iqsum_router.sv
module iqsum_router
  import iqsum_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 6,
  parameter int unsigned CH_IDX     = 0,
  parameter int unsigned NUM_ROUTES = 3,
  parameter int unsigned EXTRA_LAT  = 52,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned MARK_W     = 2,
  localparam int unsigned SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rtr_en_i,
  input  logic [NUM_ROUTES-1:0]       route_en_i,
  input  logic [NUM_ROUTES*SRC_W-1:0] route_src_i,
  input  logic                        clr_i,
  input  logic signed [SAMPLE_W-1:0]  own_i_i,
  input  logic signed [SAMPLE_W-1:0]  own_q_i,
  input  logic [MARK_W-1:0]           mark_i,
  input  logic [NUM_SRC*SAMPLE_W-1:0] bank_i_i,
  input  logic [NUM_SRC*SAMPLE_W-1:0] bank_q_i,
  output logic signed [SAMPLE_W-1:0]  out_i_o,
  output logic signed [SAMPLE_W-1:0]  out_q_o,
  output logic [MARK_W-1:0]           mark_o,
  output logic [CNT_W-1:0]            ovf_cnt_o,
  output logic                        cfg_err_o
);
  localparam int unsigned WORD_W = MARK_W + 2*SAMPLE_W;

  logic [NUM_ROUTES-1:0] route_ok, route_bad;
  sample_t               sum_i, sum_q;
  logic                  ovf;

  iqsum_route_chk #(
    .NUM_ROUTES (NUM_ROUTES),
    .NUM_SRC    (NUM_SRC),
    .CH_IDX     (CH_IDX),
    .SRC_W      (SRC_W)
  ) u_route_chk (
    .route_en_i  (route_en_i),
    .route_src_i (route_src_i),
    .route_ok_o  (route_ok),
    .route_bad_o (route_bad)
  );

  iqsum_adder #(
    .NUM_ROUTES (NUM_ROUTES),
    .NUM_SRC    (NUM_SRC),
    .SRC_W      (SRC_W)
  ) u_adder (
    .own_i_i     (own_i_i),
    .own_q_i     (own_q_i),
    .bank_i_i    (bank_i_i),
    .bank_q_i    (bank_q_i),
    .route_ok_i  (route_ok),
    .route_src_i (route_src_i),
    .sum_i_o     (sum_i),
    .sum_q_o     (sum_q),
    .ovf_o       (ovf)
  );

  logic [WORD_W-1:0] stg_q, byp_q, dly;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
      byp_q <= '0;
    end else begin
      stg_q <= {mark_i, sum_i, sum_q};
      byp_q <= {mark_i, own_i_i, own_q_i};
    end
  end

  iqsum_delay #(
    .WIDTH (WORD_W),
    .DEPTH (EXTRA_LAT)
  ) u_align (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (stg_q),
    .d_o    (dly)
  );

  logic [WORD_W-1:0] out_word;
  assign out_word = rtr_en_i ? dly : byp_q;
  assign mark_o   = out_word[WORD_W-1 -: MARK_W];
  assign out_i_o  = out_word[2*SAMPLE_W-1 -: SAMPLE_W];
  assign out_q_o  = out_word[SAMPLE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_cnt_o <= '0;
      cfg_err_o <= 1'b0;
    end else if (clr_i) begin
      ovf_cnt_o <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      if (rtr_en_i && ovf && !(&ovf_cnt_o)) ovf_cnt_o <= ovf_cnt_o + 1'b1;
      if (rtr_en_i && |route_bad) cfg_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/iqsum_router_chk.sv
module iqsum_router_chk #(
  parameter int unsigned NUM_ROUTES = 3,
  parameter int unsigned CH_IDX     = 0,
  parameter int unsigned SRC_W      = 3,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned MARK_W     = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        rtr_en_i,
  input logic                        clr_i,
  input logic [NUM_ROUTES-1:0]       route_en_i,
  input logic [NUM_ROUTES*SRC_W-1:0] route_src_i,
  input logic signed [15:0]          own_i_i,
  input logic signed [15:0]          own_q_i,
  input logic [MARK_W-1:0]           mark_i,
  input logic signed [15:0]          out_i_o,
  input logic signed [15:0]          out_q_o,
  input logic [MARK_W-1:0]           mark_o,
  input logic [CNT_W-1:0]            ovf_cnt_o,
  input logic                        cfg_err_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_BYPASS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !rtr_en_i |-> out_i_o == $past(own_i_i) && out_q_o == $past(own_q_i)); // R1
  AST_BYPASS_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !rtr_en_i |-> mark_o == $past(mark_i)); // R10
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rtr_en_i && !clr_i |=> $stable(ovf_cnt_o)); // R8
  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ovf_cnt_o >= $past(ovf_cnt_o)); // R9
  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ovf_cnt_o == '0 && !cfg_err_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o && !clr_i |=> cfg_err_o); // R5

  for (genvar a = 0; a < NUM_ROUTES; a++) begin : g_own
    AST_OWN_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rtr_en_i && !clr_i && route_en_i[a] &&
      int'(route_src_i[a*SRC_W +: SRC_W]) == int'(CH_IDX) |=> cfg_err_o); // R5
    for (genvar b = a + 1; b < NUM_ROUTES; b++) begin : g_pair
      AST_DUP_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rtr_en_i && !clr_i && route_en_i[a] && route_en_i[b] &&
        route_src_i[a*SRC_W +: SRC_W] == route_src_i[b*SRC_W +: SRC_W] |=> cfg_err_o); // R6
    end
  end
endmodule

bind iqsum_router iqsum_router_chk #(
  .NUM_ROUTES (NUM_ROUTES),
  .CH_IDX     (CH_IDX),
  .SRC_W      (SRC_W),
  .CNT_W      (CNT_W),
  .MARK_W     (MARK_W)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rtr_en_i    (rtr_en_i),
  .clr_i       (clr_i),
  .route_en_i  (route_en_i),
  .route_src_i (route_src_i),
  .own_i_i     (own_i_i),
  .own_q_i     (own_q_i),
  .mark_i      (mark_i),
  .out_i_o     (out_i_o),
  .out_q_o     (out_q_o),
  .mark_o      (mark_o),
  .ovf_cnt_o   (ovf_cnt_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/tb_iqsum_router.sv
`timescale 1ns/1ps
module tb_iqsum_router;
  localparam int NSRC = 6;
  localparam int CH   = 2;
  localparam int CW   = 4;
  localparam int NV   = 12;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rtr_en = 1'b0;
  logic [2:0]        route_en = '0;
  logic [8:0]        route_src = '0;
  logic              clr = 1'b0;
  logic signed [15:0] own_i = '0, own_q = '0;
  logic [1:0]        mark = '0;
  logic [NSRC*16-1:0] bank_i, bank_q;
  logic signed [15:0] out_i, out_q;
  logic [1:0]        mark_o;
  logic [CW-1:0]     cnt;
  logic              err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  iqsum_router #(.NUM_SRC(NSRC), .CH_IDX(CH), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rtr_en_i(rtr_en), .route_en_i(route_en),
    .route_src_i(route_src), .clr_i(clr), .own_i_i(own_i), .own_q_i(own_q),
    .mark_i(mark), .bank_i_i(bank_i), .bank_q_i(bank_q), .out_i_o(out_i),
    .out_q_o(out_q), .mark_o(mark_o), .ovf_cnt_o(cnt), .cfg_err_o(err)
  );

  typedef struct packed {
    logic [2:0]         en;
    logic [2:0]         s0, s1, s2;
    logic signed [15:0] oi, oq, ei, eq;
    logic               ov, er;
  } vec_t;

  // bank: I of source s = 1000*(s+1), Q = -100*(s+1); own channel index 2
  localparam vec_t VECS [NV] = '{
    '{3'b000, 3'd0, 3'd1, 3'd3, 16'sd100, -16'sd50, 16'sd100, -16'sd50, 1'b0, 1'b0},     // R4
    '{3'b001, 3'd0, 3'd1, 3'd3, 16'sd100, -16'sd50, 16'sd1100, -16'sd150, 1'b0, 1'b0},   // R3
    '{3'b111, 3'd0, 3'd1, 3'd3, 16'sd100, -16'sd50, 16'sd7100, -16'sd750, 1'b0, 1'b0},   // R3
    '{3'b011, 3'd2, 3'd5, 3'd0, 16'sd100, -16'sd50, 16'sd6100, -16'sd650, 1'b0, 1'b1},   // R5 own idx
    '{3'b111, 3'd4, 3'd4, 3'd1, 16'sd100, -16'sd50, 16'sd7100, -16'sd750, 1'b0, 1'b1},   // R6
    '{3'b001, 3'd7, 3'd0, 3'd0, 16'sd100, -16'sd50, 16'sd100, -16'sd50, 1'b0, 1'b1},     // R5 range
    '{3'b111, 3'd3, 3'd4, 3'd5, 16'sd20000, -16'sd100, 16'sd32767, -16'sd1600, 1'b1, 1'b0}, // R7
    '{3'b111, 3'd3, 3'd4, 3'd5, 16'sd20000, -16'sd32000, 16'sd32767, 16'h8000, 1'b1, 1'b0}, // R8 once
    '{3'b100, 3'd0, 3'd0, 3'd0, 16'h8000, 16'sd32767, -16'sd31768, 16'sd32667, 1'b0, 1'b0}, // R7 edge
    '{3'b011, 3'd1, 3'd1, 3'd0, 16'sd0, 16'sd0, 16'sd2000, -16'sd200, 1'b0, 1'b1},       // R6
    '{3'b110, 3'd2, 3'd0, 3'd1, 16'sd5, 16'sd5, 16'sd3005, -16'sd295, 1'b0, 1'b0},       // R4
    '{3'b010, 3'd3, 3'd3, 3'd0, 16'sd0, 16'sd0, 16'sd4000, -16'sd400, 1'b0, 1'b0}        // R4
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    route_en = '0; own_i = '0; own_q = '0; mark = '0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int s = 0; s < NSRC; s++) begin
      bank_i[s*16 +: 16] = 16'(1000 * (s + 1));
      bank_q[s*16 +: 16] = 16'(-100 * (s + 1));
    end
    own_i = 16'sd999; own_q = 16'sd999; mark = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset cnt", int'(cnt), 0);
    chk("R9 reset err", int'(err), 0);
    chk("R9 reset out_i", int'(out_i), 0);
    rst_ni = 1'b1;

    // bypass
    @(negedge clk);
    rtr_en = 1'b0; route_en = 3'b111; route_src = {3'd3, 3'd1, 3'd2};
    own_i = 16'sd1234; own_q = -16'sd4321; mark = 2'd3;
    @(posedge clk); @(negedge clk);
    chk("R1 bypass i", int'(out_i), 1234);
    chk("R1 bypass q", int'(out_q), -4321);
    chk("R10 bypass mark", int'(mark_o), 3);
    chk("R5 no err in bypass", int'(err), 0);
    route_src = {3'd3, 3'd1, 3'd0}; own_i = 16'sd32767;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R1 bypass ignores routes", int'(out_i), 32767);
    chk("R8 held in bypass", int'(cnt), 0);

    // latency
    idle(); rtr_en = 1'b1;
    repeat (60) @(posedge clk);
    @(negedge clk) begin own_i = 16'sd777; own_q = -16'sd777; mark = 2'd2; end
    @(posedge clk); @(negedge clk) idle();
    repeat (51) @(posedge clk); @(negedge clk);
    chk("R2 not before 53", int'(out_i), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 at 53 i", int'(out_i), 777);
    chk("R2 at 53 q", int'(out_q), -777);
    chk("R10 mark aligned", int'(mark_o), 2);
    pulse_clr();

    // vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      route_en = VECS[v].en; route_src = {VECS[v].s2, VECS[v].s1, VECS[v].s0};
      own_i = VECS[v].oi; own_q = VECS[v].oq; mark = 2'(v);
      @(posedge clk); @(negedge clk) idle();
      repeat (52) @(posedge clk); @(negedge clk);
      chk($sformatf("R3/R7 vec%0d i", v), int'(out_i), int'(VECS[v].ei));
      chk($sformatf("R3/R7 vec%0d q", v), int'(out_q), int'(VECS[v].eq));
      chk($sformatf("R10 vec%0d mark", v), int'(mark_o), v % 4);
      chk($sformatf("R8 vec%0d cnt", v), int'(cnt), int'(VECS[v].ov));
      chk($sformatf("R5/R6 vec%0d err", v), int'(err), int'(VECS[v].er));
      pulse_clr();
    end

    // counter saturation
    @(negedge clk);
    route_en = 3'b001; route_src = {3'd0, 3'd0, 3'd0}; own_i = 16'sd32767;
    repeat (20) @(posedge clk);
    @(negedge clk) idle();
    chk("R9 saturate", int'(cnt), 15);
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R9 stays at max", int'(cnt), 15);
    @(negedge clk) begin route_en = 3'b001; route_src = {3'd0, 3'd0, 3'd2}; end
    @(negedge clk) idle();
    chk("R5 err set", int'(err), 1);
    pulse_clr();
    chk("R9 clr cnt", int'(cnt), 0);
    chk("R9 clr err", int'(err), 0);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule